// File: doc/BRIEF.md
# Core Memory Read-Pause-Write Sequencer

This controller sits between a processor request port and the drive and sense circuits of a two-dimensional ferrite core array that has no data buffer. Each accepted request runs one fixed cycle. First comes a read window, in which the digit read current starts a few clocks before the word read current so that digit noise can settle. A sense strobe near the end of that window captures the sense amplifier outputs. A fixed pause follows, and then a write window puts data back into the cores, because a read clears every core that held a one.

The write window drives the word line for the whole window and drives a bit's digit line only where that bit is one. A zero is written by leaving its digit line quiet, so no inhibit current is used. A plain read writes back the sensed data and a write stores the request data. A read-modify-write stores replacement data from the processor if that data arrives during the pause, and otherwise writes back the sensed data. The latched address is decoded into a one-hot row select and a one-hot column select for the 16 by 16 word-line grid, a word-current polarity bit that picks one of the two cores at each crossing, and a block bit that selects the upper or lower half of the array.

Top module: `core_rpw_seq`

## Requirements
- R1: In reset, and at once when reset is asserted during an access, busy, done, rd_valid, sense_strobe, all drive enables, digit_wr_en, row_sel and col_sel are all 0.
- R2: A request seen in idle starts a cycle in which busy stays high for 32 clocks (3 stagger + 8 read + 12 pause + 8 write + 1 done). done is high only in the last of those clocks, and busy is low on the clock after.
- R3: digit_rd_en rises in the first busy clock, 3 clocks before word_rd_en. Both stay high until the end of the 8-clock read window and fall together.
- R4: sense_strobe is high for exactly one clock, the 7th clock of the word read window (offset 6). The sense inputs from that clock appear on rd_data, with a one-clock rd_valid pulse, in the next clock, which comes before the pause.
- R5: During the 12 pause clocks, no read enable, no write enable, no digit write bit and no strobe is active.
- R6: word_wr_en is high for the 8 clocks that follow the pause. digit_wr_en carries the write pattern, with bit i set only where bit i is 1, and it is all zero outside that window.
- R7: Mode 2'b00 (read), and the spare code 2'b11, write back the data that was sensed.
- R8: Mode 2'b01 (write) writes the req_wdata captured with the request. Later changes on req_wdata have no effect.
- R9: In mode 2'b10 (read-modify-write), a mod_valid in any pause clock loads mod_wdata as the write pattern. mod_valid outside the pause is ignored, and without it the sensed data is written back.
- R10: row_sel is one-hot on address bits [7:4] and col_sel is one-hot on bits [3:0], only while word read or word write current is on, and all zero otherwise. word_phase follows address bit 8 and block_sel follows bit 9, both taken from the address captured with the request.
- R11: req_valid while busy is ignored. The cycle in progress keeps its address and timing, and no new cycle starts after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only in idle |
| req_mode | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| req_addr | input | 10 | [3:0] column, [7:4] row, [8] polarity, [9] block |
| req_wdata | input | 12 | Write data for mode 01 |
| mod_valid | input | 1 | Replacement data valid (read-modify-write, pause only) |
| mod_wdata | input | 12 | Replacement data |
| sense_in | input | 12 | Sense amplifier outputs |
| busy | output | 1 | High for the whole cycle |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_valid | output | 1 | One-clock pulse, rd_data valid |
| rd_data | output | 12 | Captured read data |
| digit_rd_en | output | 1 | Digit read current enable |
| word_rd_en | output | 1 | Word read current enable |
| sense_strobe | output | 1 | Sense amplifier strobe |
| word_wr_en | output | 1 | Word write current enable |
| digit_wr_en | output | 12 | Per-bit digit write current enables |
| row_sel | output | 16 | One-hot word-line row select |
| col_sel | output | 16 | One-hot word-line column select |
| word_phase | output | 1 | Word current polarity (core select) |
| block_sel | output | 1 | Upper or lower block select |

## Verification
Two things can meet at the boundary between the pause and the write window: the load of replacement data and the start of the write current. The bench drives mod_valid in the last pause clock and expects that data on digit_wr_en in the first write clock. It also drives mod_valid one clock before the pause and one clock after it, and expects the sensed data to be written back in both cases. A stray request in the middle of a cycle changes req_addr at the same time. The bench then checks that the write-window selects still match the first address and that busy stays low after done.

// File: rtl/crw_pkg.sv
package crw_pkg;

  typedef enum logic [1:0] {
    MODE_READ     = 2'b00,
    MODE_WRITE    = 2'b01,
    MODE_RMW      = 2'b10,
    MODE_READ_ALT = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_STAGGER,
    PH_READ,
    PH_PAUSE,
    PH_WRITE,
    PH_DONE
  } phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/crw_sequencer.sv
module crw_sequencer
  import crw_pkg::*;
#(
  parameter int STAGGER_CYC = 3,
  parameter int RD_CYC      = 8,
  parameter int STROBE_AT   = 6,
  parameter int PAUSE_CYC   = 12,
  parameter int WR_CYC      = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  output logic   start,
  output phase_e phase,
  output logic   digit_rd_en,
  output logic   word_rd_en,
  output logic   sense_strobe,
  output logic   rd_valid,
  output logic   in_pause,
  output logic   word_wr_en,
  output logic   busy,
  output logic   done
);

  localparam int MAX_LEN = max_of(max_of(STAGGER_CYC, RD_CYC), max_of(PAUSE_CYC, WR_CYC));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  phase_e             ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   last_idx;
  logic               rdv_q;

  // length of the current phase, as the index of its last clock
  always_comb begin
    case (ph_q)
      PH_STAGGER: last_idx = CNT_W'(STAGGER_CYC - 1);
      PH_READ:    last_idx = CNT_W'(RD_CYC - 1);
      PH_PAUSE:   last_idx = CNT_W'(PAUSE_CYC - 1);
      PH_WRITE:   last_idx = CNT_W'(WR_CYC - 1);
      default:    last_idx = '0;
    endcase
  end

  // next-state logic
  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    start = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          ph_d  = PH_STAGGER;
          cnt_d = '0;
          start = 1'b1;
        end
      end
      PH_DONE: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
      default: begin
        if (cnt_q == last_idx) begin
          cnt_d = '0;
          case (ph_q)
            PH_STAGGER: ph_d = PH_READ;
            PH_READ:    ph_d = PH_PAUSE;
            PH_PAUSE:   ph_d = PH_WRITE;
            default:    ph_d = PH_DONE;
          endcase
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      rdv_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rdv_q <= sense_strobe;
    end
  end

  assign phase        = ph_q;
  assign digit_rd_en  = (ph_q == PH_STAGGER) || (ph_q == PH_READ);
  assign word_rd_en   = (ph_q == PH_READ);
  assign sense_strobe = (ph_q == PH_READ) && (cnt_q == CNT_W'(STROBE_AT));
  assign rd_valid     = rdv_q;
  assign in_pause     = (ph_q == PH_PAUSE);
  assign word_wr_en   = (ph_q == PH_WRITE);
  assign busy         = (ph_q != PH_IDLE);
  assign done         = (ph_q == PH_DONE);

  // R3: word read current never starts without digit current already on
  p_stagger_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_rd_en) |-> $past(digit_rd_en));

  // R3: digit and word read currents end in the same clock
  p_read_end_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(digit_rd_en) |-> $fell(word_rd_en));

  // R4: one strobe, followed by the data-valid pulse
  p_strobe_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sense_strobe |=> (rd_valid && !sense_strobe));

  // R2: done ends the cycle
  p_done_then_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R11: a running cycle cannot be cut short by new requests
  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/crw_addr_decode.sv
module crw_addr_decode #(
  parameter int GRID   = 16,
  localparam int SEL_W  = $clog2(GRID),
  localparam int ADDR_W = 2 * SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              word_on,
  output logic [GRID-1:0]   row_sel,
  output logic [GRID-1:0]   col_sel,
  output logic              word_phase,
  output logic              block_sel
);

  localparam int COL_LO = 0;
  localparam int ROW_LO = SEL_W;
  localparam int POL_B  = 2 * SEL_W;
  localparam int BLK_B  = 2 * SEL_W + 1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SEL_W-1:0]  row_idx, col_idx;

  always_comb begin
    addr_d = addr_q;
    if (load) addr_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign row_idx = addr_q[ROW_LO +: SEL_W];
  assign col_idx = addr_q[COL_LO +: SEL_W];

  for (genvar i = 0; i < GRID; i++) begin : g_sel
    assign row_sel[i] = word_on && (row_idx == SEL_W'(i));
    assign col_sel[i] = word_on && (col_idx == SEL_W'(i));
  end

  assign word_phase = addr_q[POL_B];
  assign block_sel  = addr_q[BLK_B];

  // R10: at most one row line at a time
  p_row_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel) && $onehot0(col_sel));

  // R11: selects do not move while word current keeps flowing
  p_sel_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_on && $past(word_on)) |-> ($stable(row_sel) && $stable(col_sel)));

endmodule

// File: rtl/crw_datapath.sv
module crw_datapath
  import crw_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        req_mode,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              strobe,
  input  logic [DATA_W-1:0] sense_in,
  input  logic              in_pause,
  input  logic              mod_valid,
  input  logic [DATA_W-1:0] mod_wdata,
  input  logic              wr_active,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] digit_wr_en
);

  mode_e             mode_q, mode_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic              take_mod;

  assign take_mod = in_pause && mod_valid && (mode_q == MODE_RMW);

  always_comb begin
    mode_d = mode_q;
    rd_d   = rd_q;
    wbuf_d = wbuf_q;
    if (start) begin
      mode_d = mode_e'(req_mode);
      wbuf_d = req_wdata;
    end
    if (strobe) begin
      rd_d = sense_in;
      if (mode_q != MODE_WRITE) wbuf_d = sense_in;
    end
    if (take_mod) wbuf_d = mod_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_READ;
      rd_q   <= '0;
      wbuf_q <= '0;
    end else begin
      mode_q <= mode_d;
      rd_q   <= rd_d;
      wbuf_q <= wbuf_d;
    end
  end

  assign rd_data     = rd_q;
  assign digit_wr_en = wr_active ? wbuf_q : '0;

  // R6: the pattern on the digit lines is steady for the whole write window
  p_wr_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_active && $past(wr_active)) |-> $stable(digit_wr_en));

  // R7: a plain read restores what it sensed
  p_plain_read_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_active && (mode_q == MODE_READ || mode_q == MODE_READ_ALT)) |-> (digit_wr_en == rd_q));

endmodule

// File: rtl/core_rpw_seq.sv
module core_rpw_seq
  import crw_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int GRID        = 16,
  parameter int STAGGER_CYC = 3,
  parameter int RD_CYC      = 8,
  parameter int STROBE_AT   = 6,
  parameter int PAUSE_CYC   = 12,
  parameter int WR_CYC      = 8,
  localparam int ADDR_W     = 2 * $clog2(GRID) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              mod_valid,
  input  logic [DATA_W-1:0] mod_wdata,
  input  logic [DATA_W-1:0] sense_in,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              digit_rd_en,
  output logic              word_rd_en,
  output logic              sense_strobe,
  output logic              word_wr_en,
  output logic [DATA_W-1:0] digit_wr_en,
  output logic [GRID-1:0]   row_sel,
  output logic [GRID-1:0]   col_sel,
  output logic              word_phase,
  output logic              block_sel
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       start;
  phase_e     phase;
  logic       in_pause;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  crw_sequencer #(
    .STAGGER_CYC (STAGGER_CYC),
    .RD_CYC      (RD_CYC),
    .STROBE_AT   (STROBE_AT),
    .PAUSE_CYC   (PAUSE_CYC),
    .WR_CYC      (WR_CYC)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_valid    (req_valid),
    .start        (start),
    .phase        (phase),
    .digit_rd_en  (digit_rd_en),
    .word_rd_en   (word_rd_en),
    .sense_strobe (sense_strobe),
    .rd_valid     (rd_valid),
    .in_pause     (in_pause),
    .word_wr_en   (word_wr_en),
    .busy         (busy),
    .done         (done)
  );

  crw_addr_decode #(
    .GRID (GRID)
  ) i_dec (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (start),
    .addr_in    (req_addr),
    .word_on    (word_rd_en || word_wr_en),
    .row_sel    (row_sel),
    .col_sel    (col_sel),
    .word_phase (word_phase),
    .block_sel  (block_sel)
  );

  crw_datapath #(
    .DATA_W (DATA_W)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .req_mode    (req_mode),
    .req_wdata   (req_wdata),
    .strobe      (sense_strobe),
    .sense_in    (sense_in),
    .in_pause    (in_pause),
    .mod_valid   (mod_valid),
    .mod_wdata   (mod_wdata),
    .wr_active   (word_wr_en),
    .rd_data     (rd_data),
    .digit_wr_en (digit_wr_en)
  );

  // R5: nothing is driven or strobed while the cycle pauses
  p_pause_quiet_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == PH_PAUSE) |-> (!digit_rd_en && !word_rd_en && !word_wr_en && !sense_strobe && digit_wr_en == '0));

endmodule

// File: tb/test_core_rpw_seq.sv
`timescale 1ns/1ps
module test_core_rpw_seq;

  logic        clk, rst_n;
  logic        req_valid, mod_valid;
  logic [1:0]  req_mode;
  logic [9:0]  req_addr;
  logic [11:0] req_wdata, mod_wdata, sense_in;
  logic        busy, done, rd_valid, digit_rd_en, word_rd_en, sense_strobe, word_wr_en;
  logic [11:0] rd_data, digit_wr_en;
  logic [15:0] row_sel, col_sel;
  logic        word_phase, block_sel;

  int n_chk = 0;
  int n_bad = 0;

  core_rpw_seq i_core_rpw_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .req_wdata(req_wdata), .mod_valid(mod_valid),
    .mod_wdata(mod_wdata), .sense_in(sense_in), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .digit_rd_en(digit_rd_en),
    .word_rd_en(word_rd_en), .sense_strobe(sense_strobe), .word_wr_en(word_wr_en),
    .digit_wr_en(digit_wr_en), .row_sel(row_sel), .col_sel(col_sel),
    .word_phase(word_phase), .block_sel(block_sel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // mode, addr, wdata, sense, mod_valid clock (0 = none), mod data
  localparam int NV = 8;
  localparam logic [53:0] VEC [NV] = '{
    {2'd0, 10'h0A5, 12'hFFF, 12'hA5C, 6'd0,  12'h000},
    {2'd1, 10'h3F0, 12'h5A3, 12'hFFF, 6'd0,  12'h000},
    {2'd2, 10'h10F, 12'h000, 12'h123, 6'd15, 12'hC3E},
    {2'd2, 10'h270, 12'h000, 12'h0F0, 6'd24, 12'h777},
    {2'd2, 10'h011, 12'h000, 12'h9A9, 6'd11, 12'h666},
    {2'd3, 10'h2FF, 12'h111, 12'h000, 6'd0,  12'h000},
    {2'd2, 10'h000, 12'h000, 12'h001, 6'd23, 12'h800},
    {2'd2, 10'h1C3, 12'hABC, 12'h456, 6'd12, 12'h0E1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle_outputs(input string tag);
    chk(busy == 0 && done == 0 && rd_valid == 0 && sense_strobe == 0, {tag, " R1 status"},
        {28'd0, busy, done, rd_valid, sense_strobe}, 32'd0);
    chk(digit_rd_en == 0 && word_rd_en == 0 && word_wr_en == 0 && digit_wr_en == 0,
        {tag, " R1 drives"}, {19'd0, digit_rd_en, word_rd_en, word_wr_en, digit_wr_en}, 32'd0);
    chk(row_sel == 0 && col_sel == 0, {tag, " R1 selects"}, {row_sel, col_sel}, 32'd0);
  endtask

  task automatic run_access(input logic [1:0] m, input logic [9:0] a, input logic [11:0] wd,
                            input logic [11:0] sn, input int mv_at, input logic [11:0] md,
                            input int intr_at);
    int first_dig = 0, last_dig = 0, first_wrd = 0, last_wrd = 0;
    int strobe_k = 0, strobe_n = 0, rdv_k = 0, rdv_n = 0;
    int first_wr = 0, wr_n = 0, done_k = 0, done_n = 0, busy_n = 0;
    bit pause_bad = 0, dw_out_bad = 0, dw_mis = 0, busy_after = 0;
    logic [11:0] rdat = '0, dw_seen = '0, exp_w;
    logic [15:0] row_r = '0, col_r = '0, row_w = '0, col_w = '0, row_p = '1;
    logic        ph_s = 0, blk_s = 0;
    if (m == 2'd1)                                     exp_w = wd;
    else if (m == 2'd2 && mv_at >= 12 && mv_at <= 23)  exp_w = md;
    else                                               exp_w = sn;
    req_valid = 1; req_mode = m; req_addr = a; req_wdata = wd; sense_in = sn; mod_wdata = md;
    @(negedge clk);
    req_valid = 0; req_wdata = ~wd; req_mode = ~m;
    for (int k = 1; k <= 34; k++) begin
      mod_valid = (k == mv_at);
      req_valid = (k == intr_at);
      if (k == intr_at) req_addr = ~a;
      #1;
      if (digit_rd_en) begin if (first_dig == 0) first_dig = k; last_dig = k; end
      if (word_rd_en)  begin if (first_wrd == 0) first_wrd = k; last_wrd = k; end
      if (sense_strobe) begin strobe_k = k; strobe_n++; end
      if (rd_valid) begin rdv_k = k; rdv_n++; rdat = rd_data; end
      if (word_wr_en) begin
        if (first_wr == 0) begin first_wr = k; dw_seen = digit_wr_en; end
        wr_n++;
        if (digit_wr_en != exp_w) dw_mis = 1;
      end else if (digit_wr_en != 0) dw_out_bad = 1;
      if (k >= 12 && k <= 23 &&
          (digit_rd_en || word_rd_en || word_wr_en || sense_strobe || digit_wr_en != 0)) pause_bad = 1;
      if (busy && k <= 32) busy_n++;
      if (busy && k > 32) busy_after = 1;
      if (done) begin done_k = k; done_n++; end
      if (k == 4)  begin row_r = row_sel; col_r = col_sel; end
      if (k == 12) begin row_p = row_sel | col_sel; ph_s = word_phase; blk_s = block_sel; end
      if (k == 24) begin row_w = row_sel; col_w = col_sel; end
      @(negedge clk);
    end
    mod_valid = 0; req_valid = 0;
    chk(first_dig == 1 && first_wrd == 4, "R3 stagger start", {first_dig[15:0], first_wrd[15:0]}, {16'd1, 16'd4});
    chk(last_dig == 11 && last_wrd == 11, "R3 read end", {last_dig[15:0], last_wrd[15:0]}, {16'd11, 16'd11});
    chk(strobe_k == 10 && strobe_n == 1, "R4 strobe", {strobe_k[15:0], strobe_n[15:0]}, {16'd10, 16'd1});
    chk(rdv_k == 11 && rdv_n == 1, "R4 rd_valid", {rdv_k[15:0], rdv_n[15:0]}, {16'd11, 16'd1});
    chk(rdat == sn, "R4 rd_data", rdat, sn);
    chk(!pause_bad, "R5 pause quiet", pause_bad, 0);
    chk(first_wr == 24 && wr_n == 8, "R6 write window", {first_wr[15:0], wr_n[15:0]}, {16'd24, 16'd8});
    chk(!dw_out_bad, "R6 digit outside window", dw_out_bad, 0);
    if (m == 2'd1)      chk(!dw_mis && dw_seen == exp_w, "R8 write data", dw_seen, exp_w);
    else if (m == 2'd2) chk(!dw_mis && dw_seen == exp_w, "R9 rmw data", dw_seen, exp_w);
    else                chk(!dw_mis && dw_seen == exp_w, "R7 restore", dw_seen, exp_w);
    chk(busy_n == 32 && done_k == 32 && done_n == 1, "R2 cycle length",
        {busy_n[15:0], done_k[7:0], done_n[7:0]}, {16'd32, 8'd32, 8'd1});
    chk(!busy_after, "R2 R11 idle after done", busy_after, 0);
    chk(row_r == (16'h1 << a[7:4]) && col_r == (16'h1 << a[3:0]), "R10 read selects",
        {row_r, col_r}, {16'h1 << a[7:4], 16'h1 << a[3:0]});
    chk(row_w == (16'h1 << a[7:4]) && col_w == (16'h1 << a[3:0]), "R10 R11 write selects",
        {row_w, col_w}, {16'h1 << a[7:4], 16'h1 << a[3:0]});
    chk(row_p == 0, "R10 selects off in pause", row_p, 0);
    chk(ph_s == a[8] && blk_s == a[9], "R10 phase and block", {ph_s, blk_s}, {a[8], a[9]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; mod_valid = 0; req_mode = 0; req_addr = 0;
    req_wdata = 0; mod_wdata = 0; sense_in = 0;
    repeat (3) @(negedge clk);
    chk_idle_outputs("reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_idle_outputs("after release");

    for (int v = 0; v < NV; v++) begin
      run_access(VEC[v][53:52], VEC[v][51:42], VEC[v][41:30], VEC[v][29:18],
                 int'(VEC[v][17:12]), VEC[v][11:0], 0);
    end

    // R11: a request while busy, with a different address
    run_access(2'd0, 10'h1B7, 12'h000, 12'h3C3, 0, 12'h000, 15);

    // R1: reset during the read window
    req_valid = 1; req_mode = 2'd0; req_addr = 10'h055; sense_in = 12'hFFF;
    @(negedge clk);
    req_valid = 0;
    repeat (7) @(negedge clk);
    rst_n = 0;
    #1;
    chk_idle_outputs("mid-access reset");
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_idle_outputs("recovered");

    run_access(2'd1, 10'h2A9, 12'hF0F, 12'h000, 0, 12'h000, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule